// File: doc/BRIEF.md
# Serial Clock-Calendar and NVRAM Slave

This block is the far end of a three-wire, software-driven serial link to a clock-calendar with a small battery-backed scratch memory. A host toggles an enable line, a clock line and a data line. While enable is held high, every falling edge of the serial clock moves one bit. The first eight bits form a command byte and the next eight form a data byte, both most significant bit first. Read commands make the block return the addressed byte one bit per falling edge during the second byte. Write commands take effect when the sixteenth bit has been taken.

The block holds a 32-byte scratch memory, a status byte and a control byte. It also returns calendar fields in packed BCD, converted from binary time inputs that an external timekeeper supplies. One command acknowledges a pending flag: it clears two status bits and sends a one-cycle request to clear the matching interrupt. Lowering enable at any point abandons the transaction.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the status byte reads 0x90 and the control byte reads 0x00. Scratch byte i reads 0xA5 XOR ((i*0x1D) mod 256). dout_o, dout_vld_o and irq_clr_o are 0.
- R2: While en_i is low the transaction is idle, and the shifted command and data are cleared. Dropping en_i part way through a write commits nothing, and the next transaction starts cleanly at bit 0.
- R3: A bit is taken only when en_i is high and sclk_i was 1 at the previous clock sample and is 0 now. Bits 0–7 fill the command and bits 8–15 fill the data byte, both MSB first.
- R4: On the falling edges of bits 8–15 of a readable command, dout_o takes bit (15 − n) of the selected byte, where n is the bit number, and dout_vld_o goes to 1. Both hold until the next falling edge. For any other command, and on any other falling edge, dout_o and dout_vld_o are 0.
- R5: Commands 0x00–0x1F read scratch byte [command].
- R6: Commands 0x80–0x9F write the data byte into scratch byte [command − 0x80] on the sixteenth falling edge.
- R7: Command 0x30 reads the status byte and command 0x31 reads the control byte.
- R8: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return packed BCD of the following values, with the tens digit in the high nibble:
  - seconds
  - minutes
  - hours
  - day of month
  - mon_i + 1
  - year_i − 100
- R9: The other commands in 0x20–0x2F are readable and return 0x00.
- R10: Command 0xB1 with data bit 2 set clears status bits 4 and 3 on the sixteenth edge, and irq_clr_o pulses high for exactly one cycle. With data bit 2 clear, nothing changes and there is no pulse.
- R11: Falling edges after the sixteenth, up to the drop of en_i, change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Transaction enable from the host register |
| sclk_i | input | 1 | Serial clock from the host register |
| sdata_i | input | 1 | Serial data from the host |
| sec_i | input | 6 | Seconds, binary 0–59 |
| min_i | input | 6 | Minutes, binary 0–59 |
| hour_i | input | 5 | Hours, binary 0–23 |
| mday_i | input | 5 | Day of month, binary 1–31 |
| mon_i | input | 4 | Month, binary 0–11 |
| year_i | input | 8 | Years since 1900, binary 100–199 |
| dout_o | output | 1 | Returned data bit |
| dout_vld_o | output | 1 | dout_o is driven by a read |
| irq_clr_o | output | 1 | One-cycle request to clear the flag interrupt |

## Verification
The bench aims at these corner cases, and names the fault each would show:
- **Abort after twelve bits.** A design that kept the partial data would corrupt a scratch byte. One that kept the old command would misframe the next transaction.
- **Edges past the sixteenth.** A design that keeps shifting would overwrite a just-written byte with trailing bits.
- **Level on sclk_i with no edge.** A design that samples levels instead of edges would take extra bits and shift every later field.
- **BCD fields.** Month and year are where an off-by-one or a missing offset shows, and the unused calendar codes show whether a gap returns garbage instead of zero.
- **Acknowledge with and without data bit 2.** A design that ignored the bit would clear status unconditionally.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int          BYTE_W   = 8;
  localparam int          NPHASE   = 16;
  localparam logic [7:0]  CMD_WR   = 8'h80;
  localparam logic [7:0]  CMD_STAT = 8'h30;
  localparam logic [7:0]  CMD_CTRL = 8'h31;
  localparam logic [7:0]  CMD_ACK  = 8'hB1;
  localparam logic [3:0]  CMD_TIME = 4'h2;
  localparam logic [7:0]  STAT_RST = 8'h90;
  localparam logic [7:0]  CTRL_RST = 8'h00;
  localparam logic [7:0]  STAT_ACK_MASK = 8'h18;
  localparam int          ACK_BIT  = 2;

  // binary 0..99 -> packed BCD
  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] t, o;
    t = v / 8'd10;
    o = v % 8'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] init_byte(input int i);
    logic [7:0] m;
    m = 8'(i * 29);
    return 8'hA5 ^ m;
  endfunction
endpackage

// File: rtl/rtc_shifter.sv
module rtc_shifter
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] wval_o,
  output logic             commit_o,
  output logic             fall_o,
  output logic             rd_fire_o,
  output logic [2:0]       bit_idx_o
);
  localparam int PW = $clog2(NPHASE + 2);
  localparam logic [PW-1:0] PH_END = PW'(NPHASE);
  localparam logic [PW-1:0] PH_SAT = PW'(NPHASE + 1);
  localparam logic [PW-1:0] PH_CMD = PW'(BYTE_W);

  logic              sclk_q, idle_q;
  logic [PW-1:0]     ph_q, ph_eff;
  logic [BYTE_W-1:0] cmd_q, val_q;

  assign ph_eff  = idle_q ? '0 : ph_q;
  assign fall_o  = en_i & sclk_q & ~sclk_i;
  assign wval_o  = {val_q[BYTE_W-2:0], sdata_i};
  assign cmd_o   = cmd_q;
  assign commit_o  = fall_o && (ph_eff == PH_END - 1'b1);
  assign rd_fire_o = fall_o && (ph_eff >= PH_CMD) && (ph_eff < PH_END);
  assign bit_idx_o = ~ph_eff[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      idle_q <= 1'b1;
      ph_q   <= '0;
      cmd_q  <= '0;
      val_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (!en_i) begin
        idle_q <= 1'b1;
        ph_q   <= '0;
        cmd_q  <= '0;
        val_q  <= '0;
      end else begin
        idle_q <= 1'b0;
        if (fall_o) begin
          if (ph_eff < PH_CMD)      cmd_q <= {cmd_q[BYTE_W-2:0], sdata_i};
          else if (ph_eff < PH_END) val_q <= wval_o;
          ph_q <= (ph_eff == PH_SAT) ? PH_SAT : ph_eff + 1'b1;
        end else begin
          ph_q <= ph_eff;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_time_bcd.sv
module rtc_time_bcd
  import rtc_pkg::*;
(
  input  logic [3:0]        sel_i,
  input  logic [5:0]        sec_i,
  input  logic [5:0]        min_i,
  input  logic [4:0]        hour_i,
  input  logic [4:0]        mday_i,
  input  logic [3:0]        mon_i,
  input  logic [7:0]        year_i,
  output logic [BYTE_W-1:0] bcd_o
);
  always_comb begin
    unique case (sel_i)
      4'h0:    bcd_o = to_bcd({2'b00, sec_i});
      4'h1:    bcd_o = to_bcd({2'b00, min_i});
      4'h2:    bcd_o = to_bcd({3'b000, hour_i});
      4'h4:    bcd_o = to_bcd({3'b000, mday_i});
      4'h5:    bcd_o = to_bcd({4'h0, mon_i} + 8'd1);
      4'h6:    bcd_o = to_bcd(year_i - 8'd100);
      default: bcd_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int RAM_DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] wval_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] time_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic              readable_o,
  output logic              irq_clr_o
);
  localparam int AW = $clog2(RAM_DEPTH);

  logic [BYTE_W-1:0] ram_q [RAM_DEPTH];
  logic [BYTE_W-1:0] stat_q, ctrl_q;
  logic              irq_q;
  logic              wr_hit, ack_hit;
  logic [AW-1:0]     wr_idx, rd_idx;

  assign wr_hit  = commit_i && (int'(cmd_i) >= int'(CMD_WR)) &&
                   (int'(cmd_i) < int'(CMD_WR) + RAM_DEPTH);
  assign ack_hit = commit_i && (cmd_i == CMD_ACK) && wval_i[ACK_BIT];
  assign wr_idx  = AW'(cmd_i - CMD_WR);
  assign rd_idx  = AW'(cmd_i);
  assign irq_clr_o = irq_q;

  always_comb begin
    readable_o = 1'b1;
    rbyte_o    = '0;
    if (int'(cmd_i) < RAM_DEPTH)       rbyte_o = ram_q[rd_idx];
    else if (cmd_i[7:4] == CMD_TIME)   rbyte_o = time_i;
    else if (cmd_i == CMD_STAT)        rbyte_o = stat_q;
    else if (cmd_i == CMD_CTRL)        rbyte_o = ctrl_q;
    else                               readable_o = 1'b0;
  end

  generate
    for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          ram_q[g] <= init_byte(g);
        else if (wr_hit && wr_idx == AW'(g))  ram_q[g] <= wval_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST;
      ctrl_q <= CTRL_RST;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ack_hit;
      if (ack_hit) stat_q <= stat_q & ~STAT_ACK_MASK;
    end
  end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_pkg::*;
#(
  parameter int RAM_DEPTH = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [4:0] mday_i,
  input  logic [3:0] mon_i,
  input  logic [7:0] year_i,
  output logic       dout_o,
  output logic       dout_vld_o,
  output logic       irq_clr_o
);
  logic [BYTE_W-1:0] cmd, wval, tbyte, rbyte;
  logic              commit, fall, rd_fire, readable;
  logic [2:0]        bit_idx;
  logic              dout_q, vld_q;

  rtc_shifter u_shift (
    .clk_i, .rst_ni, .en_i, .sclk_i, .sdata_i,
    .cmd_o(cmd), .wval_o(wval), .commit_o(commit), .fall_o(fall),
    .rd_fire_o(rd_fire), .bit_idx_o(bit_idx)
  );

  rtc_time_bcd u_time (
    .sel_i(cmd[3:0]), .sec_i, .min_i, .hour_i, .mday_i, .mon_i, .year_i,
    .bcd_o(tbyte)
  );

  rtc_regfile #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
    .clk_i, .rst_ni, .cmd_i(cmd), .wval_i(wval), .commit_i(commit),
    .time_i(tbyte), .rbyte_o(rbyte), .readable_o(readable),
    .irq_clr_o(irq_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (!en_i) begin
      dout_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (fall) begin
      vld_q  <= rd_fire & readable;
      dout_q <= rd_fire & readable & rbyte[bit_idx];
    end
  end

  assign dout_o     = dout_q;
  assign dout_vld_o = vld_q;
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sclk_i,
  input logic dout_o,
  input logic dout_vld_o,
  input logic irq_clr_o
);
  logic sclk_d, run_q, en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      en_d   <= en_i;
      run_q  <= 1'b1;
    end
  end

  // R2
  idle_no_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !dout_vld_o && !dout_o);

  // R4
  hold_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && en_i && en_d && !(sclk_d && !sclk_i) |=> $stable(dout_o) && $stable(dout_vld_o));

  // R4
  dout_only_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_o |-> dout_vld_o);

  // R10
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> !irq_clr_o);

  // R3
  clr_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && en_i && !(sclk_d && !sclk_i) |=> !irq_clr_o);
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_i(sclk_i),
  .dout_o(dout_o), .dout_vld_o(dout_vld_o), .irq_clr_o(irq_clr_o)
);

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [5:0] sec = 6'd0, mnt = 6'd0;
  logic [4:0] hour = 5'd0, mday = 5'd1;
  logic [3:0] mon = 4'd0;
  logic [7:0] year = 8'd100;
  logic dout, dvld, irq_clr;
  int checks = 0, fails = 0, clr_cnt = 0;
  logic [7:0] ram_m [32];
  logic [7:0] stat_m;
  logic [7:0] rd_b;
  logic       rd_v;

  always #4 clk = ~clk;

  rtc_serial_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sclk_i(sclk), .sdata_i(sdata),
    .sec_i(sec), .min_i(mnt), .hour_i(hour), .mday_i(mday), .mon_i(mon),
    .year_i(year), .dout_o(dout), .dout_vld_o(dvld), .irq_clr_o(irq_clr)
  );

  always @(posedge clk) if (irq_clr) clr_cnt++;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] time_exp(input logic [7:0] c);
    case (c)
      8'h20: return bcd(int'(sec));
      8'h21: return bcd(int'(mnt));
      8'h22: return bcd(int'(hour));
      8'h24: return bcd(int'(mday));
      8'h25: return bcd(int'(mon) + 1);
      8'h26: return bcd(int'(year) - 100);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bit: data + clock high, then clock low
  task automatic bit_out(input logic b, input int n);
    @(negedge clk); sdata = b; sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (n >= 8) begin
      rd_b[15-n] = dout;
      rd_v = rd_v & dvld;
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int nbits);
    logic [15:0] w;
    w = {c, v};
    rd_b = 8'h00; rd_v = 1'b1;
    @(negedge clk); sclk = 1'b1; en = 1'b1;
    for (int i = 0; i < nbits; i++) bit_out((i < 16) ? w[15-i] : 1'b1, i);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] c, input logic [7:0] exp);
    xfer(c, 8'h00, 16);
    chk(req, {24'h0, rd_b}, {24'h0, exp});
    chk(req, {31'h0, rd_v}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ram_m[i] = 8'hA5 ^ 8'(i * 29);
    stat_m = 8'h90;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk("R1 dout", {31'h0, dout}, 0);
    chk("R1 vld", {31'h0, dvld}, 0);
    chk("R1 clr", {31'h0, irq_clr}, 0);
    // R1 R7 reset status/control, R5 RAM image
    rd_chk("R1 R7 status", 8'h30, 8'h90);
    rd_chk("R1 R7 control", 8'h31, 8'h00);
    rd_chk("R1 R5 ram0", 8'h00, ram_m[0]);
    rd_chk("R1 R5 ram31", 8'h1F, ram_m[31]);
    // R4 non-readable command leaves output undriven
    xfer(8'h40, 8'h00, 16);
    chk("R4 no drive", {31'h0, rd_v}, 0);
    chk("R4 no data", {24'h0, rd_b}, 0);
    // R6 write then read
    xfer(8'h85, 8'h3C, 16); ram_m[5] = 8'h3C;
    rd_chk("R6 R5 wr5", 8'h05, 8'h3C);
    xfer(8'h9F, 8'hC3, 16); ram_m[31] = 8'hC3;
    rd_chk("R6 top", 8'h1F, 8'hC3);
    // R2 abort after 12 bits
    xfer(8'h85, 8'hFF, 12);
    rd_chk("R2 abort", 8'h05, 8'h3C);
    // R11 trailing edges after commit
    xfer(8'h87, 8'h0F, 22); ram_m[7] = 8'h0F;
    rd_chk("R11 extra", 8'h07, 8'h0F);
    // R3 clock level held low across clocks: no extra bit
    @(negedge clk); sclk = 1'b0; en = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b0; @(negedge clk);
    rd_chk("R3 level", 8'h07, 8'h0F);
    // R8 R9 time fields, fixed then random
    sec = 6'd59; mnt = 6'd7; hour = 5'd23; mday = 5'd31; mon = 4'd11; year = 8'd199;
    for (int c = 8'h20; c <= 8'h2F; c++) rd_chk((c inside {8'h23, [8'h27:8'h2F]}) ? "R9 zero" : "R8 bcd",
                                                  8'(c), time_exp(8'(c)));
    for (int k = 0; k < 6; k++) begin
      sec = 6'($urandom_range(59)); mnt = 6'($urandom_range(59));
      hour = 5'($urandom_range(23)); mday = 5'($urandom_range(31, 1));
      mon = 4'($urandom_range(11)); year = 8'($urandom_range(199, 100));
      for (int c = 8'h20; c <= 8'h26; c++) rd_chk("R8 rand", 8'(c), time_exp(8'(c)));
    end
    // R10 acknowledge without bit 2
    xfer(8'hB1, 8'hFB, 16);
    chk("R10 no pulse", clr_cnt, 0);
    rd_chk("R10 keep", 8'h30, 8'h90);
    // R10 acknowledge with bit 2
    xfer(8'hB1, 8'h04, 16); stat_m = 8'h80;
    chk("R10 pulse", clr_cnt, 1);
    rd_chk("R10 clear", 8'h30, stat_m);
    // R5 R6 random mix
    for (int k = 0; k < 40; k++) begin
      logic [4:0] a;
      logic [7:0] v;
      a = 5'($urandom); v = 8'($urandom);
      if ($urandom_range(1)) begin
        xfer(8'h80 | 8'(a), v, 16); ram_m[a] = v;
      end else rd_chk("R5 rand", 8'(a), ram_m[a]);
    end
    for (int i = 0; i < 32; i++) rd_chk("R6 sweep", 8'(i), ram_m[i]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule